// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block places incoming frames into a circular region of buffer memory that is divided into 256-byte pages. Two configuration inputs set the ring. The first page belongs to the ring. The end page is the first page past the ring and is never used. A frame is stored starting at the current page. The first four bytes of that page are kept back for a header, and the frame bytes follow from offset 4. When a frame runs past the last ring page, it continues on the first ring page. Once the last byte has arrived, the block spends four cycles writing the header: status, link to the next free page, and the two length bytes. It then moves the current page to that link.

The host frees pages by writing a release pointer. This pointer names the last page the host has finished with. The block never stores into that page. If a frame would grow into it, the block pulses an overwrite warning, drops the rest of the frame, writes no header, and leaves the current page unchanged. The receive side is a plain byte stream: a valid strobe, a last-byte marker and three error flags that come with the last byte. The source must leave at least four idle cycles after each last byte.

Top module: `rx_page_ring`

## Requirements
- R1: While reset is low at a clock edge, the current page loads `ring_first` and the release pointer loads `ring_end - 1`. No memory write and no overwrite warning is issued during reset.
- R2: The first byte of a frame is written to offset 4 of the current page. Each following byte goes to the next byte address.
- R3: When a byte would fall on page `ring_end`, it goes instead to page `ring_first` at the same in-page offset.
- R4: In the four cycles after the last byte, the header is written to offsets 0, 1, 2 and 3 of the frame's first page, in this order: status, next page, length bits 7:0, length bits 15:8. Bytes that arrive during these cycles are not stored.
- R5: The length field counts every byte received for the frame, including the four check-sequence bytes.
- R6: The status byte is built as follows. Bit 0 is set when all of `rx_err` is zero. Bit 1 is `rx_err[0]` (CRC error). Bit 2 is `rx_err[1]` (framing error). Bit 3 is `rx_err[2]` (FIFO overrun). Bits 7:4 are zero.
- R7: The next-page field is the page after the one holding the last byte, wrapped to `ring_first`. `cur_page` takes this value at the edge that ends the fourth header cycle.
- R8: If the frame would advance into the release page, either while crossing a page during the frame or through its next-page link, then `ovw_warn` pulses for one cycle. The remaining bytes are ignored, no header is written, `cur_page` is unchanged, and nothing is ever written into the release page.
- R9: A host write through `rel_we` sets the release pointer at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_first | input | 8 | First page of the ring |
| ring_end | input | 8 | Page just past the ring (excluded) |
| rel_we | input | 1 | Host write strobe for the release pointer |
| rel_page | input | 8 | New release pointer value |
| rx_valid | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_err | input | 3 | Error flags with the last byte: {overrun, framing, crc} |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 16 | Buffer byte address {page, offset} |
| mem_wdata | output | 8 | Buffer write data |
| cur_page | output | 8 | Page where the next frame will start |
| rel_ptr | output | 8 | Release pointer (last page freed by the host) |
| ovw_warn | output | 1 | One-cycle overwrite warning |

## Verification
The bench covers four boundary cases.
- A frame whose bytes end exactly on a page boundary. A design that got this wrong would link one page too far, or not far enough.
- Frames that cross the end of the ring. A wrong design would store bytes in the excluded page.
- Frames that grow into the release page, both in the middle of the frame and only through the next-page link. A wrong design would overwrite unread data, or would move the current page past a dropped frame.
- Mixed error flags. These catch a shuffled status byte.

Random lengths, combined with releases that happen only some of the time, exercise many different ring fill levels.

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int PAGE_W    = 8,
  parameter int OFS_W     = 8,
  parameter int LEN_W     = 16,
  parameter int HDR_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PAGE_W-1:0]         ring_first,
  input  logic [PAGE_W-1:0]         ring_end,
  input  logic                      rel_we,
  input  logic [PAGE_W-1:0]         rel_page,
  input  logic                      rx_valid,
  input  logic [7:0]                rx_byte,
  input  logic                      rx_last,
  input  logic [2:0]                rx_err,
  output logic                      mem_we,
  output logic [PAGE_W+OFS_W-1:0]   mem_addr,
  output logic [7:0]                mem_wdata,
  output logic [PAGE_W-1:0]         cur_page,
  output logic [PAGE_W-1:0]         rel_ptr,
  output logic                      ovw_warn
);
  localparam int ADDR_W = PAGE_W + OFS_W;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_HDR, S_DROP} st_t;

  st_t               st;
  logic [PAGE_W-1:0] wr_page, nxt_q;
  logic [OFS_W-1:0]  wr_ofs;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        hdr_idx;
  logic [7:0]        stat_q;

  wire               take     = rx_valid && (st == S_IDLE || st == S_DATA);
  wire [PAGE_W-1:0]  page_now = (st == S_IDLE) ? cur_page : wr_page;
  wire [OFS_W-1:0]   ofs_now  = (st == S_IDLE) ? OFS_W'(HDR_BYTES) : wr_ofs;
  wire [PAGE_W-1:0]  pg_inc   = page_now + 1'b1;
  wire [PAGE_W-1:0]  pg_next  = (pg_inc == ring_end) ? ring_first : pg_inc;
  wire               crossing = &ofs_now;
  wire               hit      = rx_last ? (pg_next == rel_ptr) : (crossing && pg_next == rel_ptr);
  wire [LEN_W-1:0]   len_now  = (st == S_IDLE) ? LEN_W'(1) : len_q + 1'b1;

  assign mem_we   = take || st == S_HDR;
  assign mem_addr = (st == S_HDR) ? {cur_page, OFS_W'(hdr_idx)} : {page_now, ofs_now};

  always_comb begin
    mem_wdata = rx_byte;
    if (st == S_HDR) begin
      case (hdr_idx)
        2'd0:    mem_wdata = stat_q;
        2'd1:    mem_wdata = 8'(nxt_q);
        2'd2:    mem_wdata = len_q[7:0];
        default: mem_wdata = len_q[15:8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_page <= ring_first;
      rel_ptr  <= ring_end - 1'b1;
      ovw_warn <= 1'b0;
      wr_page  <= '0;
      wr_ofs   <= '0;
      nxt_q    <= '0;
      len_q    <= '0;
      hdr_idx  <= '0;
      stat_q   <= '0;
    end else begin
      ovw_warn <= 1'b0;
      if (rel_we) rel_ptr <= rel_page;
      case (st)
        S_IDLE, S_DATA: if (rx_valid) begin
          if (hit) begin
            ovw_warn <= 1'b1;
            st       <= rx_last ? S_IDLE : S_DROP;
          end else if (rx_last) begin
            st      <= S_HDR;
            hdr_idx <= '0;
            nxt_q   <= pg_next;
            len_q   <= len_now;
            stat_q  <= {4'b0, rx_err, ~|rx_err};
          end else begin
            st      <= S_DATA;
            wr_page <= crossing ? pg_next : page_now;
            wr_ofs  <= ofs_now + 1'b1;
            len_q   <= len_now;
          end
        end
        S_HDR: begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == 2'd3) begin
            cur_page <= nxt_q;
            st       <= S_IDLE;
          end
        end
        default: if (rx_valid && rx_last) st <= S_IDLE;
      endcase
    end
  end

  p_ring_limits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:OFS_W] >= ring_first && mem_addr[ADDR_W-1:OFS_W] < ring_end));

  p_no_bnry_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !rel_we) |-> mem_addr[ADDR_W-1:OFS_W] != rel_ptr);

  p_cur_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_warn |=> $stable(cur_page));

  p_cur_after_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) != S_HDR && $past(rst_n)) |-> $stable(cur_page));

  p_hdr_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR) |-> (mem_we && mem_addr[ADDR_W-1:OFS_W] == cur_page));

  p_rel_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_we |=> rel_ptr == $past(rel_page));
endmodule

// File: tb/rx_page_ring_test.sv
module rx_page_ring_test;
  localparam int PERIOD = 10;
  localparam logic [7:0] FIRST = 8'h40;
  localparam logic [7:0] ENDP  = 8'h46;

  logic clk = 0, rst_n = 0;
  logic rel_we = 0, rx_valid = 0, rx_last = 0;
  logic [7:0] rel_page = 0, rx_byte = 0;
  logic [2:0] rx_err = 0;
  logic mem_we, ovw_warn;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_page, rel_ptr;

  int checks = 0, errors = 0, ovw_cnt = 0, bad_wr = 0;
  logic [7:0] cap [int];
  logic [7:0] m_cur, m_bnry;
  logic [7:0] fbytes [0:2047];

  rx_page_ring uut (.clk(clk), .rst_n(rst_n), .ring_first(FIRST), .ring_end(ENDP),
    .rel_we(rel_we), .rel_page(rel_page), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_last(rx_last), .rx_err(rx_err), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_page(cur_page), .rel_ptr(rel_ptr), .ovw_warn(ovw_warn));

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      cap[int'(mem_addr)] = mem_wdata;
      if (rst_n && mem_addr[15:8] == rel_ptr) bad_wr++;
    end
    if (ovw_warn) ovw_cnt++;
  end

  function automatic logic [7:0] padd(logic [7:0] p, int k);
    logic [7:0] q = p;
    for (int i = 0; i < k; i++) q = (q + 8'd1 == ENDP) ? FIRST : q + 8'd1;
    return q;
  endfunction

  function automatic logic [7:0] rd(int a);
    return cap.exists(a) ? cap[a] : 8'h00;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_all();
    logic [7:0] v = (m_cur == FIRST) ? ENDP - 8'd1 : m_cur - 8'd1;
    @(negedge clk); rel_we = 1; rel_page = v;
    @(negedge clk); rel_we = 0;
    m_bnry = v;
    chk(rel_ptr == v, "R9 release pointer load", rel_ptr, v);
  endtask

  task automatic send(int n, logic [2:0] err);
    int pages = (4 + n + 255) / 256;
    logic [7:0] nxt = padd(m_cur, pages);
    bit ovw = 0;
    int o0 = ovw_cnt;
    logic [7:0] old [4];
    int base = int'(m_cur) * 256;
    for (int k = 1; k <= pages; k++) if (padd(m_cur, k) == m_bnry) ovw = 1;
    for (int k = 0; k < 4; k++) old[k] = rd(base + k);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fbytes[i] = 8'($urandom);
      rx_valid = 1; rx_byte = fbytes[i]; rx_last = (i == n - 1);
      rx_err = (i == n - 1) ? err : 3'b0;
    end
    @(negedge clk); rx_valid = 0; rx_last = 0; rx_err = 0;
    repeat (6) @(negedge clk);
    if (ovw) begin
      chk(ovw_cnt == o0 + 1, "R8 overwrite pulse", ovw_cnt - o0, 1);
      chk(cur_page == m_cur, "R8 current page held", cur_page, m_cur);
      for (int k = 0; k < 4; k++)
        chk(rd(base + k) == old[k], "R8 no header written", rd(base + k), old[k]);
    end else begin
      bit dok = 1; int bad_i = 0;
      for (int i = 0; i < n; i++) begin
        int a = int'(padd(m_cur, (4 + i) / 256)) * 256 + (4 + i) % 256;
        if (rd(a) != fbytes[i] && dok) begin dok = 0; bad_i = i; end
      end
      chk(dok, (pages > 1) ? "R2 R3 frame data placement" : "R2 frame data placement", bad_i, 0);
      chk(rd(base) == {4'b0, err, ~|err}, "R6 status byte", rd(base), {4'b0, err, ~|err});
      chk(rd(base + 1) == nxt, "R4 R7 next page field", rd(base + 1), nxt);
      chk({rd(base + 3), rd(base + 2)} == 16'(n), "R5 length field", {rd(base + 3), rd(base + 2)}, n);
      chk(cur_page == nxt, "R7 current page advance", cur_page, nxt);
      chk(ovw_cnt == o0, "R8 no spurious warning", ovw_cnt - o0, 0);
      m_cur = nxt;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cur_page == FIRST, "R1 reset current page", cur_page, FIRST);
    chk(rel_ptr == ENDP - 8'd1, "R1 reset release pointer", rel_ptr, ENDP - 8'd1);
    chk(!mem_we && !ovw_warn, "R1 quiet in reset", {mem_we, ovw_warn}, 0);
    rst_n = 1;
    m_cur = FIRST; m_bnry = ENDP - 8'd1;
    @(negedge clk);
    send(60, 3'b000);
    release_all();
    send(252, 3'b001);
    send(64, 3'b110);
    release_all();
    send(700, 3'b010);
    release_all();
    send(500, 3'b100);
    send(1500, 3'b000);
    release_all();
    for (int f = 0; f < 40; f++) begin
      if ($urandom_range(0, 9) < 7) release_all();
      send($urandom_range(1, 900), 3'($urandom_range(0, 7)));
    end
    chk(bad_wr == 0, "R8 no write into release page", bad_wr, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule